// File: doc/BRIEF.md
# Firmware Performance-Table Scanner

This block searches a byte-addressed firmware region for a performance-state descriptor and loads the matching operating points into a small sorted table. It reads the region through a synchronous read port: `rd_en` and `rd_addr` request a byte, and `rd_data` returns it on the next cycle. The block probes a fixed signature at aligned slots. When it finds one, it checks a version byte, captures the timing fields that follow, and then walks a list of variable-length entries. It stops at the first entry whose identity and top frequency/voltage codes equal the values on its inputs.

Each (frequency code, voltage code) pair of the chosen entry goes into a table ordered by ascending frequency. An insertion moves existing entries up one slot per cycle until the new pair's position is open. When the scan ends, `done` is high and `found` reports success. The timing fields, the PLL byte, the state count and a combinational read of any table slot are then valid. Frequency in MHz is derived as 800 + 100 × code.

Top module: `perf_table_scanner`

## Requirements
- R1: The signature (parameter `SIG`, first memory byte in its most significant byte, SIG_LEN = 10) is probed only at addresses SCAN_BASE + k·SCAN_STEP that lie below SCAN_LIMIT − SIG_LEN. A copy of the signature at an unaligned address is never seen. The last slot below that bound is probed.
- R2: The six header bytes after the signature are: version, flags (ignored), settle low, settle high, packed byte, entry count. If the version is not `VERSION` (0x14), the scan ends with found = 0, and no later slot is probed.
- R3: `settle_cnt` is the little-endian 16-bit settle value. The packed byte supplies `rvo` = bits [1:0], `irt` = [3:2], `mvs` = [5:4] and `low_flag` = [7:6].
- R4: Each entry is 8 bytes: a 32-bit identity (little-endian), a PLL byte, a frequency-code byte, a voltage-code byte and a pair count. An entry matches only if the identity equals `cpu_id` and both code bytes equal the zero-extended `max_fid` and `max_vid`. A non-matching entry is skipped by 8 + 2·count bytes.
- R5: For a match, `pll_code` takes the entry's PLL byte and `n_states` takes its count. Each following pair is (frequency code in the low 6 bits of the first byte, voltage code in the low 5 bits of the second). The table is sorted by ascending frequency code, and equal codes keep their arrival order. `tbl_mhz` = 800 + 100·`tbl_fid`.
- R6: A matching entry whose count exceeds MAX_STATES ends the scan with found = 0.
- R7: If no entry under a header matches, or the header lists zero entries, probing resumes at the next aligned slot. With no slot left, the scan ends with found = 0.
- R8: `found` rises together with `done`, only after the last pair has been inserted. A matching entry with count 0 gives found = 1 and n_states = 0.
- R9: Each byte is fetched by exactly one read, and its data is used on the cycle after `rd_en`. Reads are never issued on two consecutive cycles, and none is issued while an insertion is shifting the table.
- R10: After reset, `done`, `found` and `rd_en` are 0. A `start` pulse while a scan is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan when idle or finished |
| cpu_id | input | 32 | Identity to match against entries |
| max_fid | input | 6 | Top frequency code to match |
| max_vid | input | 5 | Top voltage code to match |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory byte address |
| rd_data | input | 8 | Read data, valid one cycle after rd_en |
| done | output | 1 | Scan finished (held until next start) |
| found | output | 1 | Scan finished with a matching entry |
| settle_cnt | output | 16 | Voltage settle count from header |
| rvo | output | 2 | Ramp voltage offset field |
| irt | output | 2 | Isochronous relief time field |
| mvs | output | 2 | Maximum voltage step field |
| low_flag | output | 2 | Battery/low field |
| pll_code | output | 8 | PLL lock byte of the matched entry |
| n_states | output | CNT_W | Number of loaded states |
| tbl_idx | input | IDX_W | Table slot to read |
| tbl_fid | output | 6 | Frequency code in that slot |
| tbl_vid | output | 5 | Voltage code in that slot |
| tbl_mhz | output | FREQ_W | Frequency of that slot in MHz |

## Verification
The scanner is tried with:
- a region holding an unaligned decoy signature and a skipped entry ahead of the real one;
- a bad version ahead of a good table;
- an oversize count;
- a table whose only entry fails to match;
- an empty region;
- a zero-pair match placed in the last legal slot, with its entry wrapping around the address space.

Together these separate correct alignment, skip arithmetic, abort and resume behaviour. They are told apart by the exact number of reads as well as by the result flags. A sweep of twenty entries with one to four pairs, mixing duplicate, ascending and descending frequency codes, compares the sorted table against a stable sort computed in the bench. That sweep distinguishes a strict comparison from a non-strict one and exposes off-by-one shifting.

// File: rtl/perf_scan_pkg.sv
package perf_scan_pkg;
   localparam int FID_W = 6;
   localparam int VID_W = 5;

   typedef struct packed {
      logic [FID_W-1:0] fid;
      logic [VID_W-1:0] vid;
   } perf_pair_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SIG, ST_HDR, ST_ENT, ST_PAIR, ST_INS, ST_END
   } scan_st_t;
endpackage

// File: rtl/perf_freq_calc.sv
module perf_freq_calc
   import perf_scan_pkg::*;
#(
   parameter int FREQ_W    = 13,
   parameter int BASE_MHZ  = 800,
   parameter int STEP_MHZ  = 100,
   parameter bit SHIFT_ADD = 1'b0
) (
   input  logic [FID_W-1:0]  fid,
   output logic [FREQ_W-1:0] mhz
);
   if (SHIFT_ADD && STEP_MHZ != 100) begin : g_bad_step
      $error("shift-add variant only supports a 100 MHz step");
   end
   if (FREQ_W < 13) begin : g_bad_w
      $error("FREQ_W too narrow for the largest code");
   end

   if (SHIFT_ADD) begin : g_shift
      logic [FREQ_W-1:0] f;
      assign f   = FREQ_W'(fid);
      assign mhz = FREQ_W'(BASE_MHZ) + (f << 6) + (f << 5) + (f << 2);
   end else begin : g_mult
      assign mhz = FREQ_W'(BASE_MHZ) + FREQ_W'(fid) * FREQ_W'(STEP_MHZ);
   end
endmodule

// File: rtl/perf_sort_table.sv
module perf_sort_table
   import perf_scan_pkg::*;
#(
   parameter int MAX_STATES = 16,
   localparam int IDX_W = (MAX_STATES > 1) ? $clog2(MAX_STATES) : 1,
   localparam int CNT_W = $clog2(MAX_STATES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ins_valid,
   input  perf_pair_t       ins_pair,
   output logic             busy,
   output logic [CNT_W-1:0] fill,
   input  logic [IDX_W-1:0] rd_idx,
   output perf_pair_t       rd_pair
);
   perf_pair_t       ent [MAX_STATES];
   perf_pair_t       nw;
   logic [IDX_W-1:0] pos;
   logic             move_up;

   always_comb begin
      move_up = (pos != '0) && (ent[pos - IDX_W'(1)].fid > nw.fid);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         fill <= '0;
         pos  <= '0;
         nw   <= '0;
      end else if (clr) begin
         busy <= 1'b0;
         fill <= '0;
      end else if (busy) begin
         if (move_up) begin
            pos <= pos - IDX_W'(1);
         end else begin
            busy <= 1'b0;
            fill <= fill + CNT_W'(1);
         end
      end else if (ins_valid) begin
         busy <= 1'b1;
         nw   <= ins_pair;
         pos  <= IDX_W'(fill);
      end
   end

   for (genvar i = 0; i < MAX_STATES; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent[i] <= '0;
         end else if (busy && !clr && pos == IDX_W'(i)) begin
            if (move_up) begin
               if (i > 0) ent[i] <= ent[(i > 0) ? i - 1 : 0];
            end else begin
               ent[i] <= nw;
            end
         end
      end
      if (i + 1 < MAX_STATES) begin : g_ord
         // R5
         sorted_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy && (int'(fill) > i + 1)) |-> (ent[i].fid <= ent[i+1].fid));
      end
   end

   assign rd_pair = ent[rd_idx];

   // R6
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fill) <= MAX_STATES);
endmodule

// File: rtl/perf_scan_ctrl.sv
module perf_scan_ctrl
   import perf_scan_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int SCAN_BASE  = 32'hE0000,
   parameter int SCAN_LIMIT = 32'h100000,
   parameter int SCAN_STEP  = 16,
   parameter int SIG_LEN    = 10,
   parameter logic [8*SIG_LEN-1:0] SIG = 80'h414D444B37504E4F5721,
   parameter logic [7:0] VERSION = 8'h14,
   parameter int MAX_STATES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [31:0]       cpu_id,
   input  logic [FID_W-1:0]  max_fid,
   input  logic [VID_W-1:0]  max_vid,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   output logic              tbl_clr,
   output logic              ins_valid,
   output perf_pair_t        ins_pair,
   input  logic              tbl_busy,
   output logic              done,
   output logic              found,
   output logic [15:0]       settle,
   output logic [7:0]        packed_cfg,
   output logic [7:0]        pll_code
);
   localparam int K_W = $clog2(SIG_LEN) + 1;
   localparam logic [ADDR_W:0] SIG_END = (ADDR_W+1)'(SCAN_LIMIT - SIG_LEN);

   scan_st_t          st;
   logic              pend;
   logic [ADDR_W-1:0] addr;
   logic [ADDR_W:0]   slot, slot_nx;
   logic [K_W-1:0]    k;
   logic [7:0]        ent_left, pair_left, pll_b, fid_b, vid_b, pf;
   logic [31:0]       id_sh;
   logic              reading, id_hit, adv_slot, fail_now;

   function automatic logic [7:0] sig_byte(input logic [K_W-1:0] idx);
      return SIG[8*(SIG_LEN-1-int'(idx)) +: 8];
   endfunction

   always_comb begin
      slot_nx  = slot + (ADDR_W+1)'(SCAN_STEP);
      reading  = (st == ST_SIG) || (st == ST_HDR) || (st == ST_ENT) || (st == ST_PAIR);
      id_hit   = (id_sh == cpu_id) && (fid_b == 8'(max_fid)) && (vid_b == 8'(max_vid));
      adv_slot = pend && (((st == ST_SIG) && (rd_data != sig_byte(k))) ||
                          ((st == ST_HDR) && (k == K_W'(5)) && (rd_data == 8'd0)) ||
                          ((st == ST_ENT) && (k == K_W'(7)) && !id_hit && (ent_left == 8'd1)));
      fail_now = pend && (((st == ST_HDR) && (k == '0) && (rd_data != VERSION)) ||
                          ((st == ST_ENT) && (k == K_W'(7)) && id_hit &&
                           (int'(rd_data) > MAX_STATES)));
   end

   assign rd_en     = reading && !pend;
   assign rd_addr   = addr;
   assign tbl_clr   = start && ((st == ST_IDLE) || (st == ST_END));
   assign ins_valid = (st == ST_PAIR) && pend && (k == K_W'(1));
   assign ins_pair  = '{fid: pf[FID_W-1:0], vid: rd_data[VID_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; pend <= 1'b0; addr <= '0; slot <= '0; k <= '0;
         ent_left <= '0; pair_left <= '0; pll_b <= '0; fid_b <= '0; vid_b <= '0;
         pf <= '0; id_sh <= '0; done <= 1'b0; found <= 1'b0;
         settle <= '0; packed_cfg <= '0; pll_code <= '0;
      end else if (tbl_clr) begin
         st <= ST_SIG; pend <= 1'b0; k <= '0;
         slot <= (ADDR_W+1)'(SCAN_BASE); addr <= ADDR_W'(SCAN_BASE);
         done <= 1'b0; found <= 1'b0;
      end else if (reading && !pend) begin
         pend <= 1'b1;
      end else if (reading) begin
         pend <= 1'b0;
         if (fail_now) begin
            st <= ST_END; done <= 1'b1;
         end else if (adv_slot) begin
            if (slot_nx >= SIG_END) begin
               st <= ST_END; done <= 1'b1;
            end else begin
               st <= ST_SIG; slot <= slot_nx; addr <= slot_nx[ADDR_W-1:0]; k <= '0;
            end
         end else begin
            addr <= addr + ADDR_W'(1);
            k    <= k + K_W'(1);
            unique case (st)
               ST_SIG: if (k == K_W'(SIG_LEN-1)) begin st <= ST_HDR; k <= '0; end
               ST_HDR: begin
                  if (k == K_W'(2)) settle[7:0]  <= rd_data;
                  if (k == K_W'(3)) settle[15:8] <= rd_data;
                  if (k == K_W'(4)) packed_cfg   <= rd_data;
                  if (k == K_W'(5)) begin ent_left <= rd_data; st <= ST_ENT; k <= '0; end
               end
               ST_ENT: begin
                  if (k < K_W'(4)) id_sh <= {rd_data, id_sh[31:8]};
                  if (k == K_W'(4)) pll_b <= rd_data;
                  if (k == K_W'(5)) fid_b <= rd_data;
                  if (k == K_W'(6)) vid_b <= rd_data;
                  if (k == K_W'(7)) begin
                     k <= '0;
                     if (id_hit) begin
                        pll_code  <= pll_b;
                        pair_left <= rd_data;
                        if (rd_data == 8'd0) begin
                           st <= ST_END; done <= 1'b1; found <= 1'b1;
                        end else begin
                           st <= ST_PAIR;
                        end
                     end else begin
                        ent_left <= ent_left - 8'd1;
                        addr     <= addr + ADDR_W'(1) + ADDR_W'({rd_data, 1'b0});
                     end
                  end
               end
               default: begin
                  if (k == '0) pf <= rd_data;
                  else begin st <= ST_INS; k <= '0; end
               end
            endcase
         end
      end else if (st == ST_INS && !tbl_busy) begin
         if (pair_left == 8'd1) begin
            st <= ST_END; done <= 1'b1; found <= 1'b1;
         end else begin
            pair_left <= pair_left - 8'd1;
            st <= ST_PAIR;
         end
      end
   end

   // R1
   probe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SIG) |-> (slot < SIG_END));
   // R8
   found_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> done);
endmodule

// File: rtl/perf_table_scanner.sv
module perf_table_scanner
   import perf_scan_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int SCAN_BASE  = 32'hE0000,
   parameter int SCAN_LIMIT = 32'h100000,
   parameter int SCAN_STEP  = 16,
   parameter int SIG_LEN    = 10,
   parameter logic [8*SIG_LEN-1:0] SIG = 80'h414D444B37504E4F5721,
   parameter logic [7:0] VERSION = 8'h14,
   parameter int MAX_STATES = 16,
   parameter int FREQ_W     = 13,
   parameter bit SHIFT_ADD  = 1'b0,
   localparam int IDX_W = (MAX_STATES > 1) ? $clog2(MAX_STATES) : 1,
   localparam int CNT_W = $clog2(MAX_STATES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [31:0]       cpu_id,
   input  logic [5:0]        max_fid,
   input  logic [4:0]        max_vid,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data,
   output logic              done,
   output logic              found,
   output logic [15:0]       settle_cnt,
   output logic [1:0]        rvo,
   output logic [1:0]        irt,
   output logic [1:0]        mvs,
   output logic [1:0]        low_flag,
   output logic [7:0]        pll_code,
   output logic [CNT_W-1:0]  n_states,
   input  logic [IDX_W-1:0]  tbl_idx,
   output logic [5:0]        tbl_fid,
   output logic [4:0]        tbl_vid,
   output logic [FREQ_W-1:0] tbl_mhz
);
   if (ADDR_W < 9 || SCAN_BASE + SIG_LEN >= SCAN_LIMIT || SCAN_LIMIT > (1 << ADDR_W)) begin : g_bad_region
      $error("scan region does not fit the address width");
   end
   if (MAX_STATES < 2 || MAX_STATES > 255) begin : g_bad_depth
      $error("MAX_STATES out of range");
   end
   if (FID_W != 6 || VID_W != 5) begin : g_bad_codes
      $error("code widths must match the port widths");
   end

   logic       tbl_clr, ins_valid, tbl_busy;
   perf_pair_t ins_pair, rd_pair;
   logic [7:0] packed_cfg;

   perf_scan_ctrl #(
      .ADDR_W(ADDR_W), .SCAN_BASE(SCAN_BASE), .SCAN_LIMIT(SCAN_LIMIT),
      .SCAN_STEP(SCAN_STEP), .SIG_LEN(SIG_LEN), .SIG(SIG), .VERSION(VERSION),
      .MAX_STATES(MAX_STATES)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .cpu_id(cpu_id),
      .max_fid(max_fid), .max_vid(max_vid), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .tbl_clr(tbl_clr), .ins_valid(ins_valid),
      .ins_pair(ins_pair), .tbl_busy(tbl_busy), .done(done), .found(found),
      .settle(settle_cnt), .packed_cfg(packed_cfg), .pll_code(pll_code)
   );

   perf_sort_table #(.MAX_STATES(MAX_STATES)) i_table (
      .clk(clk), .rst_n(rst_n), .clr(tbl_clr), .ins_valid(ins_valid),
      .ins_pair(ins_pair), .busy(tbl_busy), .fill(n_states),
      .rd_idx(tbl_idx), .rd_pair(rd_pair)
   );

   perf_freq_calc #(.FREQ_W(FREQ_W), .SHIFT_ADD(SHIFT_ADD)) i_freq (
      .fid(rd_pair.fid), .mhz(tbl_mhz)
   );

   assign tbl_fid  = rd_pair.fid;
   assign tbl_vid  = rd_pair.vid;
   assign rvo      = packed_cfg[1:0];
   assign irt      = packed_cfg[3:2];
   assign mvs      = packed_cfg[5:4];
   assign low_flag = packed_cfg[7:6];

   // R9
   no_read_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_busy |-> !rd_en);
   // R9
   no_b2b_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);
endmodule

// File: tb/test_perf_table_scanner.sv
module test_perf_table_scanner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] cpu_id = '0;
   logic [5:0]  max_fid = '0;
   logic [4:0]  max_vid = '0;
   logic        rd_en;
   logic [9:0]  rd_addr;
   logic [7:0]  rd_data = '0;
   logic        done, found;
   logic [15:0] settle_cnt;
   logic [1:0]  rvo, irt, mvs, low_flag;
   logic [7:0]  pll_code;
   logic [2:0]  n_states;
   logic [1:0]  tbl_idx = '0;
   logic [5:0]  tbl_fid;
   logic [4:0]  tbl_vid;
   logic [12:0] tbl_mhz;

   int n_cmp = 0, n_bad = 0, reads = 0, b2b = 0;
   logic prev_rd = 1'b0;
   logic [7:0] mem [0:1023];
   logic [7:0] sig [10] = '{8'h41, 8'h4D, 8'h44, 8'h4B, 8'h37, 8'h50, 8'h4E, 8'h4F, 8'h57, 8'h21};

   always #5 clk = ~clk;

   perf_table_scanner #(
      .ADDR_W(10), .SCAN_BASE(32'h100), .SCAN_LIMIT(32'h400), .MAX_STATES(4)
   ) i_perf_table_scanner (
      .clk(clk), .rst_n(rst_n), .start(start), .cpu_id(cpu_id), .max_fid(max_fid),
      .max_vid(max_vid), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .done(done), .found(found), .settle_cnt(settle_cnt), .rvo(rvo), .irt(irt),
      .mvs(mvs), .low_flag(low_flag), .pll_code(pll_code), .n_states(n_states),
      .tbl_idx(tbl_idx), .tbl_fid(tbl_fid), .tbl_vid(tbl_vid), .tbl_mhz(tbl_mhz)
   );

   always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

   always @(negedge clk) begin
      if (rd_en) reads++;
      if (rd_en && prev_rd) b2b++;
      prev_rd <= rd_en;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog expired");
      summary();
      $finish;
   end

   task automatic clr_mem();
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
   endtask

   task automatic put(input int a, input int b);
      mem[a & 1023] = 8'(b);
   endtask

   task automatic put_hdr(input int a, input int ver, input int st, input int pk, input int ne);
      for (int i = 0; i < 10; i++) put(a + i, int'(sig[i]));
      put(a + 10, ver); put(a + 11, 8'hA5); put(a + 12, st & 255);
      put(a + 13, st >> 8); put(a + 14, pk); put(a + 15, ne);
   endtask

   task automatic put_ent(input int a, input logic [31:0] id, input int pll,
                          input int f, input int v, input int c);
      for (int i = 0; i < 4; i++) put(a + i, int'(id[8*i +: 8]));
      put(a + 4, pll); put(a + 5, f); put(a + 6, v); put(a + 7, c);
   endtask

   // Runs a scan; returns the number of reads issued. poke>0 pulses start mid-run.
   task automatic run_scan(input int poke, output int nrd);
      int r0;
      bit fin = 0;
      r0 = reads;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < 5000 && !fin; i++) begin
         if (done) fin = 1;
         else begin
            start = (i == poke && poke > 0);
            @(negedge clk);
         end
      end
      start = 1'b0;
      chk("R9 scan completes", int'(fin), 1);
      nrd = reads - r0;
   endtask

   task automatic chk_tbl(input int n, input int ef[4], input int ev[4], input string req);
      for (int i = 0; i < n; i++) begin
         tbl_idx = 2'(i);
         #1;
         chk(req, int'(tbl_fid), ef[i]);
         chk(req, int'(tbl_vid), ev[i]);
         chk("R5 mhz", int'(tbl_mhz), 800 + 100 * ef[i]);
      end
   endtask

   initial begin
      int nrd;
      int ef[4], ev[4];
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 done after reset", int'(done), 0);
      chk("R10 found after reset", int'(found), 0);
      chk("R10 rd_en after reset", int'(rd_en), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // T1: unaligned decoy, skipped entry, real entry at 0x200, start poked mid-run
      clr_mem();
      put_hdr(32'h108, 8'h33, 0, 0, 1);
      put_hdr(32'h200, 8'h14, 16'h1234, 8'h9C, 2);
      put_ent(32'h210, 32'h0BAD0001, 8'h11, 7, 3, 3);
      put_ent(32'h21E, 32'hC0DE1234, 8'h5A, 9, 4, 4);
      put(32'h226, 9); put(32'h227, 1); put(32'h228, 2); put(32'h229, 2);
      put(32'h22A, 9); put(32'h22B, 3); put(32'h22C, 5); put(32'h22D, 4);
      cpu_id = 32'hC0DE1234; max_fid = 9; max_vid = 4;
      run_scan(30, nrd);
      chk("R1 R4 R10 read count", nrd, 56);
      chk("R5 found", int'(found), 1);
      chk("R5 n_states", int'(n_states), 4);
      chk("R5 pll_code", int'(pll_code), 8'h5A);
      chk("R3 settle", int'(settle_cnt), 16'h1234);
      chk("R3 rvo", int'(rvo), 0);
      chk("R3 irt", int'(irt), 3);
      chk("R3 mvs", int'(mvs), 1);
      chk("R3 low", int'(low_flag), 2);
      ef = '{2, 5, 9, 9}; ev = '{2, 4, 1, 3};
      chk_tbl(4, ef, ev, "R5 stable sorted entry");

      // T2: bad version ahead of a good table
      clr_mem();
      put_hdr(32'h100, 8'h15, 0, 0, 1);
      put_hdr(32'h200, 8'h14, 0, 0, 1);
      put_ent(32'h210, 32'hC0DE1234, 0, 9, 4, 1);
      put(32'h218, 1); put(32'h219, 1);
      run_scan(0, nrd);
      chk("R2 bad version not found", int'(found), 0);
      chk("R2 bad version stops probing", nrd, 11);

      // T3: oversize count on matching entry
      clr_mem();
      put_hdr(32'h100, 8'h14, 0, 0, 1);
      put_ent(32'h110, 32'hC0DE1234, 0, 9, 4, 5);
      run_scan(0, nrd);
      chk("R6 oversize not found", int'(found), 0);
      chk("R6 oversize read count", nrd, 24);

      // T4: first table has no match, next aligned slot has one
      clr_mem();
      put_hdr(32'h100, 8'h14, 0, 0, 1);
      put_ent(32'h110, 32'h12345678, 0, 9, 4, 0);
      put_hdr(32'h120, 8'h14, 16'h0042, 8'h63, 1);
      put_ent(32'h130, 32'hC0DE1234, 8'h77, 9, 4, 1);
      put(32'h138, 6); put(32'h139, 17);
      run_scan(0, nrd);
      chk("R7 resume found", int'(found), 1);
      chk("R7 resume read count", nrd, 51);
      chk("R3 settle second", int'(settle_cnt), 16'h0042);
      chk("R3 rvo second", int'(rvo), 3);
      chk("R3 low second", int'(low_flag), 1);
      chk("R4 pll second", int'(pll_code), 8'h77);
      ef = '{6, 0, 0, 0}; ev = '{17, 0, 0, 0};
      chk_tbl(1, ef, ev, "R7 entry");

      // T5: empty region
      clr_mem();
      run_scan(0, nrd);
      chk("R7 empty not found", int'(found), 0);
      chk("R7 empty read count", nrd, 48);

      // T6: zero-pair match at last slot, entry wraps
      clr_mem();
      put_hdr(32'h3F0, 8'h14, 0, 0, 1);
      put_ent(32'h400, 32'hC0DE1234, 8'h3C, 9, 4, 0);
      run_scan(0, nrd);
      chk("R8 zero pairs found", int'(found), 1);
      chk("R8 zero pairs n_states", int'(n_states), 0);
      chk("R1 last slot read count", nrd, 71);

      // T7: sweep of pair orders
      for (int p = 0; p < 20; p++) begin
         int n, a, tf, tv;
         n = 1 + p % 4;
         a = 32'h100 + (p % 24) * 32'h20;
         clr_mem();
         cpu_id = 32'hA0000000 + p; max_fid = 6'(p % 64); max_vid = 5'(p % 32);
         put_hdr(a, 8'h14, p, p, 1);
         put_ent(a + 16, cpu_id, p, p % 64, p % 32, n);
         for (int j = 0; j < 4; j++) begin
            ef[j] = (p * 7 + j * 5 + j * j) % 9;
            ev[j] = (p + 3 * j) % 32;
         end
         for (int j = 0; j < n; j++) begin
            put(a + 24 + 2 * j, ef[j] | 8'hC0);
            put(a + 25 + 2 * j, ev[j] | 8'hE0);
         end
         for (int s = 0; s < n; s++)
            for (int j = 0; j + 1 < n; j++)
               if (ef[j] > ef[j+1]) begin
                  tf = ef[j]; ef[j] = ef[j+1]; ef[j+1] = tf;
                  tv = ev[j]; ev[j] = ev[j+1]; ev[j+1] = tv;
               end
         run_scan(0, nrd);
         chk("R8 sweep found", int'(found), 1);
         chk("R5 sweep n_states", int'(n_states), n);
         chk("R4 sweep read count", nrd, (a - 32'h100) / 16 + 24 + 2 * n);
         chk_tbl(n, ef, ev, "R5 sweep entry");
      end

      chk("R9 no back-to-back reads", b2b, 0);
      summary();
      $finish;
   end
endmodule